// File: doc/BRIEF.md
# Serial EEPROM Read-Side Target

This block is a two-wire bus target that sits in front of a byte-addressed memory and serves the read traffic of a serial EEPROM. It oversamples the clock and data lines with the system clock, finds start and stop conditions and matches the device address byte. It takes a two-byte word address through a dummy write and keeps an internal address pointer. From that pointer it answers current-address reads, random reads and sequential reads.

Its outputs are a single drive enable for an open-drain data line and a read port into a synchronous memory. The port has an address output, and the read data returns one system clock later. A dummy write that ends with a stop only moves the pointer, so a later current-address read starts there. A sequential read keeps stepping the pointer through the whole array and wraps to zero.

Top module: `seeprom_rd_target`

## Requirements
- R1: After reset the data-line drive enable is low (line released) and the memory address output is 0.
- R2: A device address byte is acknowledged only if its upper four bits are 1010 and bits 3..1 equal the select straps. Bit 0 is read (1) or write (0). On a mismatch the block does not acknowledge, and it ignores every byte until the next start condition. Its pointer is not changed.
- R3: After an acknowledged write address byte, the next two bytes are the high and then the low word address byte, and each is acknowledged. The pointer becomes the low ADDR_W bits of {high, low}, so upper bits beyond the array are ignored.
- R4: A repeated start after the word address bytes, followed by a read address byte, returns data starting at the loaded address.
- R5: A stop after the word address bytes loads the pointer without sending data, and the memory address output then shows the loaded address.
- R6: A read address byte without a preceding dummy write returns data starting at the current pointer.
- R7: Each master acknowledge after a data byte makes the block send the byte at the next address. After address 2**ADDR_W-1 the next address is 0.
- R8: A master non-acknowledge ends the read and the block goes to standby. After the read the pointer, as seen on the memory address output, is one past the last byte sent, with wrap.
- R9: Data is sent most significant bit first, an acknowledge pulls the line low, and the drive enable changes only while the clock line is low.
- R10: A start or stop inside a byte aborts the current operation. An incomplete dummy write leaves the pointer unchanged, and a start restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel_i | input | 3 | Device select straps compared with address bits 3..1 |
| sda_oe_o | output | 1 | High pulls the data line low |
| mem_addr_o | output | ADDR_W | Memory read address (current pointer) |
| mem_rdata_i | input | 8 | Memory read data, valid one clock after the address |

## Verification
The bench builds the block with ADDR_W set to 8, a 256-byte array. At that size a random read near the top address reaches the wrap to zero in a few bytes, and a high word byte of nonzero value shows that excess address bits are ignored. The default 15-bit array is left to the design alone, because the memory in the bench is a computed pattern rather than storage. A behavioural pointer model predicts every returned byte and the address output after each transaction. A per-clock monitor watches that the drive enable never moves while the clock line is high.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RXB,
    ST_RXEND,
    ST_ACK,
    ST_TXB,
    ST_TXEND,
    ST_MACK,
    ST_MACKGO,
    ST_WAIT
  } ctl_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WHI,
    PH_WLO
  } rx_phase_t;

endpackage

// File: rtl/seeprom_bus_mon.sv
module seeprom_bus_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC:0] scl_p, sda_p;
  logic          scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_i};
      sda_p <= {sda_p[SYNC-1:0], sda_i};
    end
  end

  assign scl_q    = scl_p[SYNC-1];
  assign sda_q    = sda_p[SYNC-1];
  assign scl_prev = scl_p[SYNC];
  assign sda_prev = sda_p[SYNC];

  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

  // R10: bus events are mutually exclusive in any one cycle
  a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, start_det, stop_det}));

endmodule

// File: rtl/seeprom_addr_ctr.sv
module seeprom_addr_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] cnt_o
);

  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (inc_i) cnt_d = cnt_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i || inc_i)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7: stepping from the top address lands on zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && (&cnt_q)) |=> (cnt_q == '0));

  // R10: the pointer moves only on a load or a step
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_oe_o,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] ptr_val_o,
  output logic              ptr_inc_o
);

  ctl_state_t state_q, state_d;
  rx_phase_t  phase_q, phase_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] hi_q, hi_d;
  logic       rw_q, rw_d;
  logic       ackp_q, ackp_d;
  logic       oe_q, oe_d;
  logic [7:0] byte_in;

  assign byte_in   = {sh_q[6:0], sda_q};
  assign ptr_val_o = ADDR_W'({hi_q, byte_in});

  always_comb begin
    state_d    = state_q;
    phase_d    = phase_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    hi_d       = hi_q;
    rw_d       = rw_q;
    ackp_d     = ackp_q;
    oe_d       = oe_q;
    ptr_load_o = 1'b0;
    ptr_inc_o  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_RXB;
      phase_d = PH_DEV;
      bit_d   = 3'd0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RXB: if (scl_rise) begin
          sh_d  = byte_in;
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            state_d = ST_RXEND;
            unique case (phase_q)
              PH_DEV: begin
                ackp_d = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == dev_sel_i);
                rw_d   = byte_in[0];
              end
              PH_WHI: begin
                hi_d   = byte_in;
                ackp_d = 1'b1;
              end
              default: begin
                ackp_d     = 1'b1;
                ptr_load_o = 1'b1;
              end
            endcase
          end
        end
        ST_RXEND: if (scl_fall) begin
          if (ackp_q) begin
            state_d = ST_ACK;
            oe_d    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ACK: if (scl_fall) begin
          oe_d  = 1'b0;
          bit_d = 3'd0;
          unique case (phase_q)
            PH_DEV: begin
              if (rw_q) begin
                sh_d      = mem_rdata_i;
                oe_d      = ~mem_rdata_i[7];
                ptr_inc_o = 1'b1;
                state_d   = ST_TXB;
              end else begin
                phase_d = PH_WHI;
                state_d = ST_RXB;
              end
            end
            PH_WHI: begin
              phase_d = PH_WLO;
              state_d = ST_RXB;
            end
            default: state_d = ST_WAIT;
          endcase
        end
        ST_TXB: begin
          if (scl_rise) begin
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) state_d = ST_TXEND;
          end else if (scl_fall) begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        ST_TXEND: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_MACK;
        end
        ST_MACK: if (scl_rise) begin
          state_d = sda_q ? ST_IDLE : ST_MACKGO;
        end
        ST_MACKGO: if (scl_fall) begin
          sh_d      = mem_rdata_i;
          oe_d      = ~mem_rdata_i[7];
          ptr_inc_o = 1'b1;
          bit_d     = 3'd0;
          state_d   = ST_TXB;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DEV;
      bit_q   <= 3'd0;
      sh_q    <= 8'h00;
      hi_q    <= 8'h00;
      rw_q    <= 1'b0;
      ackp_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      hi_q    <= hi_d;
      rw_q    <= rw_d;
      ackp_q  <= ackp_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

  // R9: the drive enable only moves while the clock line is low
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_q);

  // R2: in standby the data line is never pulled
  a_r2_standby_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  // R10: a start always restarts address matching with the line released
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_RXB) && (phase_q == PH_DEV) && !oe_q);

  // R8: a master non-acknowledge sends the block to standby
  a_r8_nack_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MACK && scl_rise && sda_q && !start_det && !stop_det) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/seeprom_rd_target.sv
module seeprom_rd_target #(
  parameter int ADDR_W = 15,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  seeprom_bus_mon #(.SYNC(SYNC)) i_mon (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  seeprom_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .scl_q       (scl_q),
    .sda_q       (sda_q),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .dev_sel_i   (dev_sel_i),
    .mem_rdata_i (mem_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .ptr_load_o  (ptr_load),
    .ptr_val_o   (ptr_val),
    .ptr_inc_o   (ptr_inc)
  );

  seeprom_addr_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .inc_i      (ptr_inc),
    .cnt_o      (mem_addr_o)
  );

endmodule

// File: tb/test_seeprom_rd_target.sv
`timescale 1ns/1ps
module test_seeprom_rd_target;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl, msda;
  logic [2:0]    sel;
  logic          sda_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  wire           sda_line = msda & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int ptr    = 0;
  int r9_viol = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  seeprom_rd_target #(.ADDR_W(AW)) i_seeprom_rd_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .dev_sel_i   (sel),
    .sda_oe_o    (sda_oe),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(((a * 37) + 11) ^ (a >> 2));
  endfunction

  always_ff @(posedge clk) mem_rdata <= pat(int'(mem_addr));

  // per-clock monitor for R9: no drive change while the clock line stays high
  logic scl_d, oe_d;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && scl && scl_d && (sda_oe !== oe_d)) r9_viol <= r9_viol + 1;
    scl_d <= scl;
    oe_d  <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic rd);
    msda = b; qw();
    scl = 1'b1; qw();
    rd = sda_line; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_start();
    msda = 1'b1; qw();
    scl = 1'b1; qw();
    msda = 1'b0; qw();
    scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    msda = 1'b0; qw();
    scl = 1'b1; qw();
    msda = 1'b1; qw();
  endtask

  task automatic wr_bits(input logic [7:0] b, input int n);
    logic d;
    for (int i = 7; i > 7 - n; i--) send_bit(b[i], d);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) send_bit(b[i], d);
    send_bit(1'b1, d);
    ack = ~d;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, d);
      v[i] = d;
    end
    send_bit(~mack, d);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, sel, rw};
  endfunction

  // receive n bytes after an acknowledged read address byte
  task automatic get_bytes(input int n, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      rd_byte(k < n - 1, v);
      chk(req, v, pat(ptr));
      ptr = (ptr + 1) % DEPTH;
    end
    bus_stop();
    chk("R8 pointer after read", mem_addr, ptr);
  endtask

  task automatic cur_read(input int n, input string req);
    logic a;
    bus_start();
    wr_byte(dev(1'b1), a);
    chk("R6 read address ack", a, 1);
    get_bytes(n, req);
  endtask

  task automatic dummy(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    wr_byte(dev(1'b0), a);
    chk("R2 write address ack", a, 1);
    wr_byte(hi, a);
    chk("R3 high word ack", a, 1);
    wr_byte(lo, a);
    chk("R3 low word ack", a, 1);
    ptr = int'(lo) % DEPTH;
  endtask

  task automatic rand_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    logic a;
    dummy(hi, lo);
    bus_start();
    wr_byte(dev(1'b1), a);
    chk("R4 read ack after dummy write", a, 1);
    get_bytes(n, req);
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    sel   = 3'b101;
    scl   = 1'b1;
    msda  = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 drive released", sda_oe, 0);
    chk("R1 address zero", mem_addr, 0);

    // R6 and R7: current read from reset pointer, two bytes
    cur_read(2, "R6 current read data");

    // R3 high byte beyond the array ignored, R4 random read of three bytes
    rand_read(8'hA5, 8'h37, 3, "R4 random read data");
    cur_read(1, "R6 continues after random read");

    // R5: set current address with a stop
    dummy(8'h00, 8'hF0);
    bus_stop();
    chk("R5 pointer loaded by stop", mem_addr, 8'hF0);
    cur_read(2, "R5 read from loaded pointer");

    // R7: sequential read across the top of the array
    rand_read(8'h00, 8'hFE, 4, "R7 wrap data");

    // R2: wrong select straps, then a byte that must be ignored
    bus_start();
    wr_byte({4'b1010, 3'b010, 1'b1}, a);
    chk("R2 select mismatch no ack", a, 0);
    wr_byte(8'h00, a);
    chk("R2 ignored byte no ack", a, 0);
    bus_stop();
    chk("R2 pointer kept", mem_addr, ptr);

    // R2: wrong device type
    bus_start();
    wr_byte({4'b1011, sel, 1'b0}, a);
    chk("R2 type mismatch no ack", a, 0);
    bus_stop();
    chk("R2 pointer kept after type mismatch", mem_addr, ptr);

    // R10: start inside the low word byte aborts the dummy write
    bus_start();
    wr_byte(dev(1'b0), a);
    wr_byte(8'h00, a);
    wr_bits(8'h10, 4);
    bus_start();
    wr_byte(dev(1'b1), a);
    chk("R10 ack after restart", a, 1);
    rd_byte(1'b0, v);
    chk("R10 data from old pointer", v, pat(ptr));
    ptr = (ptr + 1) % DEPTH;
    bus_stop();

    // R10: stop inside the high word byte
    bus_start();
    wr_byte(dev(1'b0), a);
    wr_bits(8'h40, 3);
    bus_stop();
    chk("R10 pointer kept after stop abort", mem_addr, ptr);
    cur_read(1, "R10 read after stop abort");

    chk("R9 drive stable while clock high", r9_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule